// File: doc/BRIEF.md
# Quadratic Spiking Neuron Step Engine

This block holds the state of one spiking neuron with quadratic membrane dynamics and advances it by one model millisecond each time its step input is high at a rising clock edge. The neuron has two state variables: a membrane potential and a recovery value that pulls the potential back down. An external current and four run-time parameters drive the update. One parameter sets how fast recovery follows the potential, one sets how strongly recovery tracks the potential, one sets the potential loaded after a spike, and one sets the recovery increment added after a spike. The integration scheme is forward Euler. All arithmetic is fixed point and clamps at the limits of the state format instead of wrapping.

A surrounding network or test harness drives the current and pulses step at the model rate. It reads the spike flag and the two state values after each step, and can stream the potential straight to a DAC or sample port. Between step pulses the state is frozen, so the model rate is independent of the clock rate.

Top module: `izh_neuron`

## Requirements
- R1: The potential, recovery value, current, after-spike potential and after-spike increment are signed two's-complement values with FRAC=8 fractional bits in DW=16 bits, so raw 256 means 1 mV. The recovery rate and coupling parameters are signed values with PFRAC=16 fractional bits, so raw 65536 would mean 1.0.
- R2: On a step, with old raw potential v, old raw recovery u and raw current I, the integrated potential is vn = sat(v + floor(2621·v²/2^24) + 5·v + 35840 − u + I). Here 2621 is 0.04 rounded to the nearest multiple of 2^-16, 35840 is 140 mV, and floor rounds toward minus infinity.
- R3: On a step, the integrated recovery value is un = sat(u + floor(a·(floor(b·v/2^16) − u)/2^16)). It uses the old v and the old u.
- R4: If vn ≥ 7680 (30 mV), the stored potential becomes the after-spike potential c instead of vn. As long as c is below 30 mV, the stored potential never reaches 30 mV.
- R5: On a step that spikes, the stored recovery value becomes sat(un + d). On a step without a spike, it becomes un.
- R6: The spike output is registered. It is 1 exactly in the cycle after a step edge whose vn met the threshold, and 0 after any edge without a step.
- R7: While step is low at a rising edge, the potential and recovery value keep their values, whatever the current and parameter inputs do.
- R8: While the synchronous reset rst is high at a rising edge, the potential is loaded with c, the recovery value with floor(b·c/2^16), and spike is cleared.
- R9: sat() clamps to [−32768, 32767]. Repeated negative drive pins the potential at −32768, and repeated spikes with a large d pin the recovery value at 32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, loads the after-spike potential and its matching recovery value |
| step | input | 1 | Advance the model by one millisecond at this edge |
| cur_i | input | DW | Input current, signed fixed point |
| par_a | input | DW | Recovery rate, signed, PFRAC fractional bits |
| par_b | input | DW | Recovery coupling, signed, PFRAC fractional bits |
| par_c | input | DW | After-spike potential, signed fixed point |
| par_d | input | DW | After-spike recovery increment, signed fixed point |
| spike | output | 1 | One-cycle flag after a step that crossed threshold |
| v_mem | output | DW | Membrane potential |
| u_rec | output | DW | Recovery value |

## Verification
Every result of a step is due one rising edge after the edge that sampled step: the new potential, the new recovery value and the spike flag all appear together. The reset values are due one edge after rst is sampled. The bench drives inputs on falling edges and records, at each rising edge, whether a step or a reset was taken. At the following falling edge it pops the expected item that its driver queued for that step, or checks that nothing moved and that spike is low. Expected items come from an integer model of R2 to R5 and R9 that the driver runs before it raises step. Spike counts over a long regular-spiking run are compared with the totals of that model.

// File: rtl/izh_pkg.sv
package izh_pkg;
   localparam int THR_MV   = 30;
   localparam int BIAS_MV  = 140;
   localparam int LIN_GAIN = 5;

   // 0.04 in a format with pfrac fractional bits, rounded to nearest
   function automatic int quad_coef(int pfrac);
      return (4 * (2 ** pfrac) + 50) / 100;
   endfunction
endpackage

// File: rtl/izh_sat.sv
module izh_sat #(
   parameter int IW = 32,
   parameter int OW = 16
) (
   input  logic signed [IW-1:0] x,
   output logic signed [OW-1:0] y
);
   generate
      if (IW <= OW) begin : g_pass
         assign y = OW'(x);
      end else begin : g_clip
         localparam logic signed [IW-1:0] MAXV = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
         localparam logic signed [IW-1:0] MINV = ~MAXV;
         always_comb begin
            if (x > MAXV)      y = MAXV[OW-1:0];
            else if (x < MINV) y = MINV[OW-1:0];
            else               y = x[OW-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/izh_vpath.sv
module izh_vpath #(
   parameter int DW    = 16,
   parameter int FRAC  = 8,
   parameter int PFRAC = 16,
   parameter int W     = 2*DW + PFRAC + 2
) (
   input  logic signed [DW-1:0] v,
   input  logic signed [DW-1:0] u,
   input  logic signed [DW-1:0] cur,
   output logic signed [W-1:0]  v_next
);
   localparam logic signed [W-1:0] K    = W'(izh_pkg::quad_coef(PFRAC));
   localparam logic signed [W-1:0] LIN  = W'(izh_pkg::LIN_GAIN);
   localparam logic signed [W-1:0] BIAS = W'(izh_pkg::BIAS_MV * (2 ** FRAC));

   logic signed [W-1:0] vw, uw, iw, sq, quad;

   assign vw   = W'(v);
   assign uw   = W'(u);
   assign iw   = W'(cur);
   assign sq   = vw * vw;
   assign quad = (K * sq) >>> (PFRAC + FRAC);
   assign v_next = vw + quad + LIN * vw + BIAS - uw + iw;
endmodule

// File: rtl/izh_upath.sv
module izh_upath #(
   parameter int DW    = 16,
   parameter int PFRAC = 16,
   parameter int W     = 2*DW + PFRAC + 2
) (
   input  logic signed [DW-1:0] v,
   input  logic signed [DW-1:0] u,
   input  logic signed [DW-1:0] rate,
   input  logic signed [DW-1:0] coup,
   output logic signed [W-1:0]  u_next
);
   logic signed [W-1:0] vw, uw, aw, bw, bv, du;

   assign vw = W'(v);
   assign uw = W'(u);
   assign aw = W'(rate);
   assign bw = W'(coup);
   assign bv = (bw * vw) >>> PFRAC;
   assign du = (aw * (bv - uw)) >>> PFRAC;
   assign u_next = uw + du;
endmodule

// File: rtl/izh_neuron.sv
module izh_neuron #(
   parameter int DW    = 16,
   parameter int FRAC  = 8,
   parameter int PFRAC = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 step,
   input  logic signed [DW-1:0] cur_i,
   input  logic signed [DW-1:0] par_a,
   input  logic signed [DW-1:0] par_b,
   input  logic signed [DW-1:0] par_c,
   input  logic signed [DW-1:0] par_d,
   output logic                 spike,
   output logic signed [DW-1:0] v_mem,
   output logic signed [DW-1:0] u_rec
);
   localparam int W = 2*DW + PFRAC + 2;
   localparam logic signed [DW-1:0] THR = DW'(izh_pkg::THR_MV * (2 ** FRAC));

   generate
      if (DW - 1 - FRAC < 6) begin : g_bad_frac
         $error("izh_neuron: FRAC leaves no room for the 30 mV threshold");
      end
      if (PFRAC < 8 || PFRAC > 24) begin : g_bad_pfrac
         $error("izh_neuron: PFRAC must lie in 8..24");
      end
   endgenerate

   logic signed [DW-1:0] v_q, u_q;
   logic                 spk_q;
   logic signed [W-1:0]  vn_w, un_w, ud_w, bc_w;
   logic signed [DW-1:0] vn_s, un_s, ud_s, u_init;
   logic signed [DW-1:0] v_d, u_d;
   logic                 fire;

   izh_vpath #(.DW(DW), .FRAC(FRAC), .PFRAC(PFRAC), .W(W)) u_vpath (
      .v(v_q), .u(u_q), .cur(cur_i), .v_next(vn_w));

   izh_upath #(.DW(DW), .PFRAC(PFRAC), .W(W)) u_upath (
      .v(v_q), .u(u_q), .rate(par_a), .coup(par_b), .u_next(un_w));

   izh_sat #(.IW(W), .OW(DW)) u_sat_v (.x(vn_w), .y(vn_s));
   izh_sat #(.IW(W), .OW(DW)) u_sat_u (.x(un_w), .y(un_s));

   assign ud_w = W'(un_s) + W'(par_d);
   izh_sat #(.IW(W), .OW(DW)) u_sat_d (.x(ud_w), .y(ud_s));

   assign bc_w = (W'(par_b) * W'(par_c)) >>> PFRAC;
   izh_sat #(.IW(W), .OW(DW)) u_sat_r (.x(bc_w), .y(u_init));

   assign fire = (vn_s >= THR);
   assign v_d  = fire ? par_c : vn_s;
   assign u_d  = fire ? ud_s  : un_s;

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q   <= par_c;
         u_q   <= u_init;
         spk_q <= 1'b0;
      end else begin
         spk_q <= step & fire;
         if (step) begin
            v_q <= v_d;
            u_q <= u_d;
         end
      end
   end

   assign spike = spk_q;
   assign v_mem = v_q;
   assign u_rec = u_q;
endmodule

// File: rtl/izh_neuron_chk.sv
module izh_neuron_chk #(
   parameter int DW   = 16,
   parameter int FRAC = 8
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 step,
   input logic signed [DW-1:0] par_c,
   input logic                 spike,
   input logic signed [DW-1:0] v_mem,
   input logic signed [DW-1:0] u_rec
);
   localparam logic signed [DW-1:0] THR = DW'(izh_pkg::THR_MV * (2 ** FRAC));

   assert_below_thr_R4: assert property (@(posedge clk) disable iff (rst)
      step |=> (v_mem < THR) || (v_mem == $past(par_c)));

   assert_spike_loads_c_R4: assert property (@(posedge clk) disable iff (rst)
      spike |-> (v_mem == $past(par_c)));

   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(v_mem) && $stable(u_rec));

   assert_spike_needs_step_R6: assert property (@(posedge clk) disable iff (rst)
      !step |=> !spike);
endmodule

bind izh_neuron izh_neuron_chk #(.DW(DW), .FRAC(FRAC)) u_chk (
   .clk(clk), .rst(rst), .step(step), .par_c(par_c),
   .spike(spike), .v_mem(v_mem), .u_rec(u_rec));

// File: tb/izh_neuron_bench.sv
`timescale 1ns/1ps
module izh_neuron_bench;
   localparam longint KQ = (4 * 65536 + 50) / 100;

   logic clk = 1'b0, rst = 1'b1, step = 1'b0;
   logic signed [15:0] cur = '0, pa = '0, pb = '0, pc = '0, pd = '0;
   logic spike;
   logic signed [15:0] v_mem, u_rec;

   typedef struct { longint v; longint u; bit sp; } exp_t;
   exp_t q[$];

   int n_chk = 0, n_bad = 0;
   int ref_spk = 0, dut_spk = 0;
   longint rv = 0, ru = 0;
   longint last_v = 0, last_u = 0;
   longint min_v = 0, max_u = 0;
   logic stepped = 1'b0, rsted = 1'b1;
   bit done = 1'b0;

   izh_neuron u_izh_neuron (
      .clk(clk), .rst(rst), .step(step), .cur_i(cur),
      .par_a(pa), .par_b(pb), .par_c(pc), .par_d(pd),
      .spike(spike), .v_mem(v_mem), .u_rec(u_rec));

   always #2 clk = ~clk;

   task automatic chk(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint sat16(longint x);
      if (x > 32767) return 32767;
      if (x < -32768) return -32768;
      return x;
   endfunction

   // integer model of R2, R3, R4, R5, R9
   task automatic ref_advance(output bit sp);
      longint v, u, quad, vn, un, bv;
      v = rv; u = ru;
      quad = (KQ * v * v) >>> 24;
      vn = sat16(v + quad + 5 * v + 35840 - u + longint'(cur));
      bv = (longint'(pb) * v) >>> 16;
      un = sat16(u + ((longint'(pa) * (bv - u)) >>> 16));
      sp = (vn >= 7680);
      if (sp) begin
         rv = longint'(pc);
         ru = sat16(un + longint'(pd));
      end else begin
         rv = vn;
         ru = un;
      end
   endtask

   task automatic do_step(int gap);
      exp_t e;
      bit sp;
      ref_advance(sp);
      if (sp) ref_spk++;
      e.v = rv; e.u = ru; e.sp = sp;
      q.push_back(e);
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      rv = longint'(pc);
      ru = sat16((longint'(pb) * longint'(pc)) >>> 16);
      chk("R8 v after reset", longint'(v_mem), rv);
      chk("R8 u after reset", longint'(u_rec), ru);
      chk("R8 spike after reset", longint'(spike), 0);
   endtask

   task automatic drain();
      @(negedge clk);
      @(negedge clk);
      chk("R6 queue drained", longint'(q.size()), 0);
   endtask

   // monitor: scoreboard side
   always @(posedge clk) begin
      stepped <= step;
      rsted   <= rst;
   end

   always @(negedge clk) begin
      exp_t e;
      if (!rsted) begin
         if (stepped) begin
            if (q.size() == 0) begin
               chk("R6 result without queued step", 1, 0);
            end else begin
               e = q.pop_front();
               chk(e.sp ? "R4 v on spike" : "R2 v", longint'(v_mem), e.v);
               chk(e.sp ? "R5 u on spike" : "R3 u", longint'(u_rec), e.u);
               chk("R6 spike flag", longint'(spike), longint'(e.sp));
               if (spike) dut_spk++;
               if (longint'(v_mem) < min_v) min_v = longint'(v_mem);
               if (longint'(u_rec) > max_u) max_u = longint'(u_rec);
            end
         end else begin
            chk("R6 spike idle", longint'(spike), 0);
            chk("R7 v hold", longint'(v_mem), last_v);
            chk("R7 u hold", longint'(u_rec), last_u);
         end
      end
      last_v = longint'(v_mem);
      last_u = longint'(u_rec);
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R6 watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // regular spiking: a=0.02 b=0.2 c=-65 d=8 I=10 (R1 formats)
      pa = 16'sd1311; pb = 16'sd13107; pc = -16'sd16640; pd = 16'sd2048;
      cur = 16'sd2560;
      do_reset();
      repeat (5) @(negedge clk);
      chk("R7 v idle after reset", longint'(v_mem), longint'(pc));

      ref_spk = 0; dut_spk = 0;
      for (int i = 0; i < 1000; i++) do_step(i % 3);
      drain();
      chk("R6 spike count 1000 steps", longint'(dut_spk), longint'(ref_spk));
      chk("R4 model produced spikes", longint'(ref_spk > 0), 1);

      // inputs wiggle while idle: state must hold (R7)
      cur = 16'sh7fff; pc = 16'sd7000; pd = -16'sd3000; pa = 16'sh7fff;
      repeat (6) @(negedge clk);
      chk("R7 v after idle wiggle", longint'(v_mem), rv);
      pa = 16'sd1311; pc = -16'sd16640; pd = 16'sd2048;

      // strong negative drive: potential clamps low (R9)
      cur = 16'sh8000;
      min_v = 0;
      for (int i = 0; i < 40; i++) do_step(i % 2);
      drain();
      chk("R9 v clamps at minimum", min_v, -32768);

      // strong positive drive, large d: recovery clamps high (R9, R5)
      cur = 16'sh7fff; pd = 16'sd25600;
      max_u = -32768;
      for (int i = 0; i < 40; i++) do_step(0);
      drain();
      chk("R9 u clamps at maximum", max_u, 32767);

      // fast spiking set, back-to-back steps
      pa = 16'sd6554; pb = 16'sd13107; pc = -16'sd16640; pd = 16'sd512;
      cur = 16'sd1280;
      do_reset();
      ref_spk = 0; dut_spk = 0;
      for (int i = 0; i < 300; i++) do_step(0);
      drain();
      chk("R6 spike count fast set", longint'(dut_spk), longint'(ref_spk));

      // chattering set with reset to a higher potential
      pa = 16'sd1311; pb = 16'sd13107; pc = -16'sd12800; pd = 16'sd512;
      cur = 16'sd2560;
      do_reset();
      for (int i = 0; i < 200; i++) do_step(i % 4);
      drain();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule